// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the slave side of a two-wire serial bus in front of a 256-byte memory. It oversamples the clock and data lines in the system clock domain. From those samples it picks out START, repeated START and STOP conditions. It acknowledges only its own seven-bit device address, which includes one strap pin. The data line is modelled as a sampled input and a separate open-drain pull-down enable.

A byte address register lives inside the block and is kept from one transaction to the next. A write transaction that carries a word address loads this register. That lets a master perform a random read: a dummy write of the word address, a repeated START, then a read. A read that sends no word address starts at the register's current value. Any read goes on byte after byte for as long as the master acknowledges each byte. The read ends when the master declines a byte and then issues STOP.

The memory behind the engine is a register file that is filled with a computed pattern at reset. No data leaves the block except over the serial line, so the block has no valid/ready interfaces. The strap and bus pins are plain level signals.

Top module: `i2c_rd_eeprom`

## Requirements
- R1: The device address byte is matched against bits 7..1 = 1,0,1,0,`a2_i`,0,0, with bit 0 as the direction bit (1 = read, 0 = write). On a mismatch the slave gives no acknowledge, leaves the address register unchanged and keeps SDA released until the next START.
- R2: The slave acknowledges a matching device address byte and a word address byte by pulling SDA low during the ninth SCL clock of that byte.
- R3: A random read returns the byte at the word address that was just written. The sequence is START, device address with write, word address, repeated START, device address with read. Data bits are sent most significant bit first.
- R4: A read that sends no word address returns the byte that follows the last byte the slave began to transmit. After reset, this starts at address 0x00.
- R5: When the master pulls SDA low in the acknowledge slot after a data byte, the slave sends the byte at the next address. A read with no STOP and no master NACK simply goes on.
- R6: When the master leaves SDA high in the acknowledge slot, the slave stops driving SDA and keeps it released so that the master can issue STOP.
- R7: The address register advances modulo 256, so a sequential read that passes 0xFF continues at 0x00.
- R8: A write transaction loads the address register from its word address byte, even if STOP follows at once. Any further data bytes in that write are not acknowledged.
- R9: A START seen at any point aborts the byte in progress and restarts device-address reception. A STOP seen at any point returns the slave to idle with SDA released.
- R10: SDA is released after reset. The slave changes its pull-down only while the synchronised SCL is low.
- R11: After reset, memory byte a holds a XOR 0x5A, with INIT_XOR at its default value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| a2_i | input | 1 | Strap bit placed at bit 3 of the device address |
| scl_i | input | 1 | Sampled level of the serial clock line |
| sda_i | input | 1 | Sampled level of the serial data line |
| sda_oe_o | output | 1 | When high, the slave pulls SDA low |

## Verification
The assertions assume the system clock runs well over four times faster than the SCL edges. They also assume that the master changes SDA only while SCL is low, except when it makes a START or STOP, and that `a2_i` does not change inside a transaction. The stimulus keeps to these conditions. Every SCL quarter lasts six system clocks, and the master changes SDA only in the quarter after SCL falls. A repeated START is issued only when the slave is not pulling the line low. The strap is changed only between transactions. The random part picks transaction kinds, word addresses and read lengths, including reads that wrap past 0xFF.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WORD,
    ST_WORD_ACK,
    ST_TX,
    ST_TX_ACK
  } rd_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  // one synchroniser chain per line
  for (genvar g = 0; g < STAGES; g++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scl_ff[g] <= 1'b1;
        sda_ff[g] <= 1'b1;
      end else if (g == 0) begin
        scl_ff[g] <= scl_i;
        sda_ff[g] <= sda_i;
      end else begin
        scl_ff[g] <= scl_ff[(g == 0) ? 0 : g-1];
        sda_ff[g] <= sda_ff[(g == 0) ? 0 : g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_lvl;
      sda_q <= sda_lvl;
    end
  end

  assign scl_lvl  = scl_ff[STAGES-1];
  assign sda_lvl  = sda_ff[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_q;
  assign scl_fall = ~scl_lvl & scl_q;
  assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2c_rd_mem.sv
module i2c_rd_mem #(
  parameter int          AW       = 8,
  parameter int          DW       = 8,
  parameter logic [7:0]  INIT_XOR = 8'h5A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // contents are loaded from a computed pattern at reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DW'(i) ^ DW'(INIT_XOR);
      rdata <= '0;
    end else begin
      rdata <= mem_q[raddr];
    end
  end
endmodule

// File: rtl/i2c_rd_fsm.sv
module i2c_rd_fsm
  import i2c_rd_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [6:0]        dev_id,
  input  logic [BYTE_W-1:0] rdata,
  output logic [AW-1:0]     addr_o,
  output logic              sda_oe_o
);
  rd_state_t         st_q;
  logic [2:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              full_q, rw_q, mack_q, oe_q;
  logic [AW-1:0]     addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; full_q <= 1'b0;
      rw_q <= 1'b0; mack_q <= 1'b0; oe_q <= 1'b0; addr_q <= '0;
    end else if (start_ev) begin
      st_q <= ST_DEV; cnt_q <= '0; full_q <= 1'b0; oe_q <= 1'b0;
    end else if (stop_ev) begin
      st_q <= ST_IDLE; full_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_WORD: begin
          if (scl_rise && !full_q) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_lvl};
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) full_q <= 1'b1;
          end else if (scl_fall && full_q) begin
            full_q <= 1'b0;
            if (st_q == ST_WORD) begin
              addr_q <= sh_q[AW-1:0];
              oe_q   <= 1'b1;
              st_q   <= ST_WORD_ACK;
            end else if (sh_q[7:1] == dev_id) begin
              rw_q <= sh_q[0];
              oe_q <= 1'b1;
              st_q <= ST_DEV_ACK;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        ST_DEV_ACK: if (scl_fall) begin
          cnt_q <= '0;
          if (rw_q) begin
            sh_q   <= rdata;
            oe_q   <= ~rdata[7];
            addr_q <= addr_q + 1'b1;
            st_q   <= ST_TX;
          end else begin
            oe_q <= 1'b0;
            st_q <= ST_WORD;
          end
        end
        ST_WORD_ACK: if (scl_fall) begin
          oe_q <= 1'b0;
          st_q <= ST_IDLE;
        end
        ST_TX: if (scl_fall) begin
          if (cnt_q == 3'd7) begin
            oe_q  <= 1'b0;
            cnt_q <= '0;
            st_q  <= ST_TX_ACK;
          end else begin
            sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
            oe_q  <= ~sh_q[6];
            cnt_q <= cnt_q + 3'd1;
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) mack_q <= ~sda_lvl;
          else if (scl_fall) begin
            if (mack_q) begin
              sh_q   <= rdata;
              oe_q   <= ~rdata[7];
              addr_q <= addr_q + 1'b1;
              st_q   <= ST_TX;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign addr_o   = addr_q;
  assign sda_oe_o = oe_q;

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_lvl);
  // R6
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !oe_q);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !oe_q);
  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DEV_ACK && scl_fall && rw_q && !start_ev && !stop_ev)
      |=> addr_q == $past(addr_q) + 1'b1);
  // R9
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st_q == ST_DEV && !oe_q));
endmodule

// File: rtl/i2c_rd_eeprom.sv
module i2c_rd_eeprom
  import i2c_rd_pkg::*;
#(
  parameter int         AW          = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_PREFIX  = 4'b1010,
  parameter logic [7:0] INIT_XOR    = 8'h5A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a2_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic [AW-1:0]     addr;
  logic [BYTE_W-1:0] rdata;
  logic [6:0]        dev_id;

  assign dev_id = {DEV_PREFIX, a2_i, 2'b00};

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_rd_mem #(.AW(AW), .DW(BYTE_W), .INIT_XOR(INIT_XOR)) u_mem (
    .clk(clk), .rst_n(rst_n), .raddr(addr), .rdata(rdata)
  );

  i2c_rd_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
    .stop_ev(stop_ev), .dev_id(dev_id), .rdata(rdata),
    .addr_o(addr), .sda_oe_o(sda_oe_o)
  );
endmodule

// File: tb/sim_i2c_rd_eeprom.sv
module sim_i2c_rd_eeprom;
  localparam int CLK_PERIOD = 10;
  localparam int Q  = 6;
  localparam int WD = 190000;

  logic clk = 1'b0, rst_n = 1'b0, a2 = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  int   errs = 0, total = 0, r10_bad = 0;
  bit   done = 1'b0;
  logic [7:0] exp_addr = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_rd_eeprom u0 (
    .clk(clk), .rst_n(rst_n), .a2_i(a2), .scl_i(scl_m),
    .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  // R10 monitor: pull-down must not move while SCL stays high
  logic scl_p = 1'b1, oe_p = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_p && (sda_oe != oe_p)) r10_bad++;
    scl_p <= scl_m;
    oe_p  <= sda_oe;
  end

  function automatic logic [7:0] mem_val(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction
  function automatic logic [7:0] dev(input logic rd);
    return {4'b1010, a2, 2'b00, rd};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qtr(); repeat (Q) @(negedge clk); endtask

  task automatic do_start();
    sda_m = 1'b1; qtr(); scl_m = 1'b1; qtr(); sda_m = 1'b0; qtr(); scl_m = 1'b0; qtr();
  endtask
  task automatic do_stop();
    sda_m = 1'b0; qtr(); scl_m = 1'b1; qtr(); sda_m = 1'b1; qtr();
  endtask
  task automatic put_bit(input logic b);
    sda_m = b; qtr(); scl_m = 1'b1; qtr(); qtr(); scl_m = 1'b0; qtr();
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1'b1; qtr(); scl_m = 1'b1; qtr(); b = sda_line; qtr(); scl_m = 1'b0; qtr();
  endtask
  task automatic put_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = ~b;
  endtask
  task automatic get_byte(input logic ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(~ack);
  endtask

  // reads n bytes after a read header was acknowledged; checks R5 R6 R7 R11
  task automatic read_body(input int n, input string req);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      get_byte(i < n - 1, v);
      chk(req, v, mem_val(exp_addr));
      exp_addr = exp_addr + 8'd1;
    end
    chk("R6 line released after NACK", sda_line, 1'b1);
    do_stop();
  endtask

  task automatic rand_read(input logic [7:0] w, input int n);
    logic ak;
    do_start();
    put_byte(dev(1'b0), ak); chk("R2 dev write ack", ak, 1'b1);
    put_byte(w, ak);         chk("R2 word ack", ak, 1'b1);
    do_start();
    put_byte(dev(1'b1), ak); chk("R2 dev read ack", ak, 1'b1);
    exp_addr = w;
    read_body(n, "R3 R5 R7 R11 random read data");
  endtask

  task automatic cur_read(input int n);
    logic ak;
    do_start();
    put_byte(dev(1'b1), ak); chk("R2 current read ack", ak, 1'b1);
    read_body(n, "R4 R5 current read data");
  endtask

  task automatic bad_dev();
    logic ak;
    do_start();
    put_byte(dev(1'b0) ^ 8'h10, ak); chk("R1 mismatch no ack", ak, 1'b0);
    put_byte(8'h33, ak);             chk("R1 ignored byte no ack", ak, 1'b0);
    do_stop();
  endtask

  initial begin
    logic ak;
    logic [3:0] hdr;
    void'($urandom(32'h1234));
    repeat (4) @(negedge clk);
    chk("R10 reset released", sda_oe, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 released after reset", sda_oe, 1'b0);

    cur_read(2);              // R4 starts at 0x00
    rand_read(8'h40, 3);      // R3 R5
    cur_read(1);              // R4 follows last byte
    rand_read(8'hFE, 4);      // R7 wrap

    // R1 mismatch leaves address untouched
    bad_dev();
    cur_read(1);

    // R8 dummy write plus data byte not acknowledged
    do_start();
    put_byte(dev(1'b0), ak); chk("R8 dev ack", ak, 1'b1);
    put_byte(8'h9C, ak);     chk("R8 word ack", ak, 1'b1);
    put_byte(8'hAA, ak);     chk("R8 data byte not acked", ak, 1'b0);
    do_stop();
    exp_addr = 8'h9C;
    cur_read(1);

    // R9 STOP during device byte, then normal read
    do_start();
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    do_stop();
    cur_read(1);

    // R9 START during word byte keeps old address
    do_start();
    put_byte(dev(1'b0), ak);
    hdr = 4'b0101;
    for (int i = 3; i >= 1; i--) put_bit(hdr[i]);
    do_start();
    put_byte(dev(1'b1), ak); chk("R9 restart ack", ak, 1'b1);
    read_body(2, "R9 read after aborted word byte");

    // R1 strap change
    a2 = 1'b1;
    do_start();
    put_byte(8'b1010_0001, ak); chk("R1 old strap rejected", ak, 1'b0);
    do_stop();
    cur_read(1);

    // constrained random mix
    for (int it = 0; it < 30; it++) begin
      int k;
      k = int'($urandom_range(0, 3));
      a2 = 1'($urandom_range(0, 1));
      if (k == 0) rand_read(8'($urandom_range(0, 255)), int'($urandom_range(1, 4)));
      else if (k == 1) cur_read(int'($urandom_range(1, 3)));
      else if (k == 2) rand_read(8'($urandom_range(250, 255)), int'($urandom_range(2, 8)));
      else bad_dev();
    end

    chk("R10 pull-down changes only with SCL low", r10_bad, 0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errs++; total++;
      $display("FAIL watchdog run hung actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end
endmodule